// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block is the command sequencer for one channel of a scatter-gather DMA engine. Software places a chain of eight-word nodes in memory. It writes the address of the first node into the channel's node register and then sets channel enable and list enable together. From that point the sequencer walks the chain on its own. For each node it reads the eight words in turn over a simple one-outstanding read port and loads them into its working registers. It then offers one transfer command to a data mover over a valid/ready handshake. The command carries source, destination, byte count, increment flags and access widths.

The data mover reports progress with byte-step pulses and finishes each command with a done pulse. The sequencer then takes the next-node pointer it loaded from the node. A zero pointer ends the chain. A pointer back to an earlier node makes the list run in a loop until software cancels it. An active-size register shows how many bytes of the current command are still to move. It uses a minus-one encoding, and reads all ones when nothing remains.

Top module: `dma_list_seq`

## Requirements
- R1: After reset, no memory read or command is requested, the control/status register (offset 0x1C) and the command counter (0x18) read zero, and the active-size register (0x30) reads 0x00FFFFFF.
- R2: Writing 0x1C with bit 0 (channel enable) and bit 4 (list enable) both set while idle starts a fetch of eight words from the address held at 0x14, at ascending addresses four bytes apart. Each read address is held until its data is returned.
- R3: After the eighth word, the block raises cmd_valid with these fields: source from word 2, destination from word 3, length from the low 24 bits of word 4, read increment from word 0 bit 8, write increment from word 0 bit 12, read width from word 0 bits 2:0 and write width from word 0 bits 6:4. The command stays stable until cmd_ready. Offsets 0x00, 0x04, 0x08, 0x0C and 0x10 read back words 0 to 4, with 0x10 masked to 24 bits. A memory read and a command are never requested in the same cycle.
- R4: Word 5 of a node is loaded into 0x14. After mv_done, a nonzero pointer causes the next fetch to start at that address.
- R5: If word 5 is zero, then after mv_done no more reads occur, bit 4 of 0x1C clears and bit 0 stays set. The low 6 bits of 0x18 count completed commands.
- R6: A node whose pointer leads back to an earlier node makes the chain repeat, fetching and issuing again without end while list enable stays set.
- R7: Writing 0x1C with bit 20 set cancels the channel. cmd_abort is high in that cycle if a command is offered or in progress. From the next cycle on there is no memory read and no command, and bits 0 and 4 read zero.
- R8: Once a command is accepted, 0x30 reads its length field. Each mv_step lowers the count by mv_bytes. The register reads 0x00FFFFFF once the step count reaches or exceeds the remaining bytes, and it reads the same whenever no command is in progress.
- R9: A read returned with mem_rerr during a fetch sets bit 24 of 0x1C, clears list enable and halts the channel without issuing the command. Bit 24 stays set until reset.
- R10: While a list is in progress, writes to 0x14 and writes to 0x1C without bit 20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset inside the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data returned for the current request |
| mem_rdata | input | 32 | Returned word |
| mem_rerr | input | 1 | Returned word is in error |
| cmd_valid | output | 1 | Transfer command offered |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_src | output | 32 | Source address |
| cmd_dst | output | 32 | Destination address |
| cmd_len | output | 24 | Byte count minus one |
| cmd_rd_inc | output | 1 | Source address increments |
| cmd_wr_inc | output | 1 | Destination address increments |
| cmd_rd_width | output | 3 | Log2 of read access bytes |
| cmd_wr_width | output | 3 | Log2 of write access bytes |
| cmd_abort | output | 1 | Current command is cancelled |
| mv_step | input | 1 | Mover moved mv_bytes bytes |
| mv_bytes | input | 4 | Bytes moved in this step |
| mv_done | input | 1 | Mover finished the current command |

## Verification
Most faults in the fetch counter or state register show up within one read handshake. A wrong word index moves mem_addr off the expected four-byte stride, or loads a field into the wrong register, and the next cmd_valid then carries a wrong source, destination or length. A fault in how the next pointer is followed shows up at the first mv_done. Reads then start at the wrong address, never start, or continue past a zero pointer, and bit 4 of the control register fails to clear. Errors in the remaining-size counter show in register 0x30 on the cycle after the accepting edge or after the step that caused them. A cancel or fetch error that does not force the idle state leaves mem_req or cmd_valid high one cycle later.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_ISSUE,
    S_WAIT,
    S_NEXT
  } seq_state_e;

  // word positions inside one list node
  localparam int unsigned W_GCFG  = 0;
  localparam int unsigned W_RPORT = 1;
  localparam int unsigned W_RADDR = 2;
  localparam int unsigned W_WADDR = 3;
  localparam int unsigned W_SIZE  = 4;
  localparam int unsigned W_NEXT  = 5;

  // register offsets in the channel window
  localparam int unsigned OFF_GCFG  = 'h00;
  localparam int unsigned OFF_RPORT = 'h04;
  localparam int unsigned OFF_RADDR = 'h08;
  localparam int unsigned OFF_WADDR = 'h0C;
  localparam int unsigned OFF_SIZE  = 'h10;
  localparam int unsigned OFF_NODE  = 'h14;
  localparam int unsigned OFF_COUNT = 'h18;
  localparam int unsigned OFF_CTRL  = 'h1C;
  localparam int unsigned OFF_ACT   = 'h30;

  // control/status bits
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_LIST   = 4;
  localparam int unsigned CB_CANCEL = 20;
  localparam int unsigned CB_ERR    = 24;

  // general config bits
  localparam int unsigned GB_INC_R  = 8;
  localparam int unsigned GB_INC_W  = 12;
  localparam int unsigned GB_RW_LSB = 0;
  localparam int unsigned GB_WW_LSB = 4;

endpackage

// File: rtl/dls_seq.sv
module dls_seq
  import dls_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic                     cancel,
  input  logic [AW-1:0]            head_addr,
  input  logic [AW-1:0]            next_addr,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     mem_rerr,
  output logic                     word_we,
  output logic [$clog2(WORDS)-1:0] word_idx,
  output logic [DW-1:0]            word_data,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  input  logic                     mv_done,
  output logic                     cmd_take,
  output logic                     cmd_fin,
  output logic                     list_end,
  output logic                     fetch_err,
  output logic                     cmd_live,
  output logic                     seq_idle
);

  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  seq_state_e       state_q, state_d;
  logic [AW-1:0]    base_q, base_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  function automatic logic [AW-1:0] f_word_addr(input logic [AW-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + AW'({idx, 2'b00});
  endfunction

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    idx_d   = idx_q;
    unique case (state_q)
      S_IDLE: begin
        if (go) begin
          state_d = S_FETCH;
          base_d  = head_addr;
          idx_d   = '0;
        end
      end
      S_FETCH: begin
        if (mem_rvalid) begin
          if (mem_rerr)              state_d = S_IDLE;
          else if (idx_q == LAST_IDX) state_d = S_ISSUE;
          else                        idx_d   = idx_q + IDX_W'(1);
        end
      end
      S_ISSUE: if (cmd_ready) state_d = S_WAIT;
      S_WAIT:  if (mv_done)   state_d = S_NEXT;
      S_NEXT: begin
        if (next_addr == '0) begin
          state_d = S_IDLE;
        end else begin
          state_d = S_FETCH;
          base_d  = next_addr;
          idx_d   = '0;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (cancel) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
    end
  end

  assign mem_req   = (state_q == S_FETCH);
  assign mem_addr  = f_word_addr(base_q, idx_q);
  assign word_idx  = idx_q;
  assign word_data = mem_rdata;
  assign word_we   = mem_req && mem_rvalid && !mem_rerr && !cancel;
  assign fetch_err = mem_req && mem_rvalid && mem_rerr && !cancel;
  assign cmd_valid = (state_q == S_ISSUE);
  assign cmd_take  = cmd_valid && cmd_ready && !cancel;
  assign cmd_fin   = (state_q == S_WAIT) && mv_done && !cancel;
  assign list_end  = (state_q == S_NEXT) && (next_addr == '0) && !cancel;
  assign cmd_live  = (state_q == S_ISSUE) || (state_q == S_WAIT);
  assign seq_idle  = (state_q == S_IDLE);

endmodule

// File: rtl/dls_regs.sv
module dls_regs
  import dls_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 24,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [OFF_W-1:0]         reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic                     seq_idle,
  input  logic                     word_we,
  input  logic [$clog2(WORDS)-1:0] word_idx,
  input  logic [DW-1:0]            word_data,
  input  logic                     cmd_fin,
  input  logic                     list_end,
  input  logic                     fetch_err,
  input  logic [LEN_W-1:0]         active_view,
  output logic                     go,
  output logic                     cancel_evt,
  output logic                     err_flag,
  output logic [AW-1:0]            node_addr,
  output logic [AW-1:0]            src_addr,
  output logic [AW-1:0]            dst_addr,
  output logic [LEN_W-1:0]         size_m1,
  output logic                     rd_inc,
  output logic                     wr_inc,
  output logic [2:0]               rd_width,
  output logic [2:0]               wr_width
);

  localparam int unsigned IDX_W = $clog2(WORDS);

  logic [DW-1:0]    gcfg_q, rport_q;
  logic [AW-1:0]    raddr_q, waddr_q, node_q;
  logic [LEN_W-1:0] size_q;
  logic [CNT_W-1:0] done_q;
  logic             en_q, list_q, err_q;
  logic             ctrl_wr, node_wr;

  function automatic logic hit(input logic [OFF_W-1:0] a, input int unsigned off);
    return a == OFF_W'(off);
  endfunction

  function automatic logic at_word(input logic [IDX_W-1:0] i, input int unsigned w);
    return i == IDX_W'(w);
  endfunction

  assign ctrl_wr    = reg_we && hit(reg_addr, OFF_CTRL);
  assign node_wr    = reg_we && hit(reg_addr, OFF_NODE);
  assign cancel_evt = ctrl_wr && reg_wdata[CB_CANCEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      list_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cancel_evt) begin
        en_q   <= 1'b0;
        list_q <= 1'b0;
      end else if (ctrl_wr && seq_idle) begin
        en_q   <= reg_wdata[CB_EN];
        list_q <= reg_wdata[CB_LIST];
      end else if (list_end || fetch_err) begin
        list_q <= 1'b0;
      end
      if (fetch_err) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q  <= '0;
      rport_q <= '0;
      raddr_q <= '0;
      waddr_q <= '0;
      size_q  <= '0;
      node_q  <= '0;
    end else if (word_we) begin
      if (at_word(word_idx, W_GCFG))  gcfg_q  <= word_data;
      if (at_word(word_idx, W_RPORT)) rport_q <= word_data;
      if (at_word(word_idx, W_RADDR)) raddr_q <= AW'(word_data);
      if (at_word(word_idx, W_WADDR)) waddr_q <= AW'(word_data);
      if (at_word(word_idx, W_SIZE))  size_q  <= word_data[LEN_W-1:0];
      if (at_word(word_idx, W_NEXT))  node_q  <= AW'(word_data);
    end else if (node_wr && seq_idle) begin
      node_q <= AW'(reg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= '0;
    else if (cmd_fin) done_q <= done_q + CNT_W'(1);
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFF_GCFG))  reg_rdata = gcfg_q;
    if (hit(reg_addr, OFF_RPORT)) reg_rdata = rport_q;
    if (hit(reg_addr, OFF_RADDR)) reg_rdata = DW'(raddr_q);
    if (hit(reg_addr, OFF_WADDR)) reg_rdata = DW'(waddr_q);
    if (hit(reg_addr, OFF_SIZE))  reg_rdata = DW'(size_q);
    if (hit(reg_addr, OFF_NODE))  reg_rdata = DW'(node_q);
    if (hit(reg_addr, OFF_COUNT)) reg_rdata = DW'(done_q);
    if (hit(reg_addr, OFF_ACT))   reg_rdata = DW'(active_view);
    if (hit(reg_addr, OFF_CTRL)) begin
      reg_rdata[CB_EN]   = en_q;
      reg_rdata[CB_LIST] = list_q;
      reg_rdata[CB_ERR]  = err_q;
    end
  end

  assign go        = en_q && list_q;
  assign err_flag  = err_q;
  assign node_addr = node_q;
  assign src_addr  = raddr_q;
  assign dst_addr  = waddr_q;
  assign size_m1   = size_q;
  assign rd_inc    = gcfg_q[GB_INC_R];
  assign wr_inc    = gcfg_q[GB_INC_W];
  assign rd_width  = gcfg_q[GB_RW_LSB +: 3];
  assign wr_width  = gcfg_q[GB_WW_LSB +: 3];

endmodule

// File: rtl/dls_remain.sv
module dls_remain #(
  parameter int unsigned LEN_W  = 24,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  size_m1,
  input  logic              step_vld,
  input  logic [STEP_W-1:0] step_bytes,
  input  logic              clear,
  output logic [LEN_W-1:0]  active_view
);

  localparam int unsigned CW = LEN_W + 1;

  logic [CW-1:0] rem_q;

  function automatic logic [CW-1:0] f_total(input logic [LEN_W-1:0] m1);
    return {1'b0, m1} + CW'(1);
  endfunction

  function automatic logic [CW-1:0] f_after(input logic [CW-1:0] rem,
                                            input logic [STEP_W-1:0] b);
    logic [CW-1:0] bx;
    bx = CW'(b);
    return (rem > bx) ? rem - bx : '0;
  endfunction

  function automatic logic [LEN_W-1:0] f_view(input logic [CW-1:0] rem);
    logic [CW-1:0] m1;
    m1 = rem - CW'(1);
    return (rem == '0) ? '1 : m1[LEN_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem_q <= '0;
    else if (clear)    rem_q <= '0;
    else if (load)     rem_q <= f_total(size_m1);
    else if (step_vld) rem_q <= f_after(rem_q, step_bytes);
  end

  assign active_view = f_view(rem_q);

endmodule

// File: rtl/dma_list_seq.sv
module dma_list_seq
  import dls_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned LEN_W     = 24,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned WORDS     = 8,
  parameter int unsigned STEP_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_we,
  input  logic [$clog2(WIN_BYTES)-1:0]   reg_addr,
  input  logic [DW-1:0]                  reg_wdata,
  output logic [DW-1:0]                  reg_rdata,
  output logic                           mem_req,
  output logic [AW-1:0]                  mem_addr,
  input  logic                           mem_rvalid,
  input  logic [DW-1:0]                  mem_rdata,
  input  logic                           mem_rerr,
  output logic                           cmd_valid,
  input  logic                           cmd_ready,
  output logic [AW-1:0]                  cmd_src,
  output logic [AW-1:0]                  cmd_dst,
  output logic [LEN_W-1:0]               cmd_len,
  output logic                           cmd_rd_inc,
  output logic                           cmd_wr_inc,
  output logic [2:0]                     cmd_rd_width,
  output logic [2:0]                     cmd_wr_width,
  output logic                           cmd_abort,
  input  logic                           mv_step,
  input  logic [STEP_W-1:0]              mv_bytes,
  input  logic                           mv_done
);

  localparam int unsigned OFF_W = $clog2(WIN_BYTES);
  localparam int unsigned IDX_W = $clog2(WORDS);

  // named internal events, also used by the checker
  logic             go, cancel_evt, err_flag, seq_idle, cmd_live;
  logic             word_we, cmd_take, cmd_fin, list_end, fetch_err;
  logic [IDX_W-1:0] word_idx;
  logic [DW-1:0]    word_data;
  logic [AW-1:0]    node_addr;
  logic [LEN_W-1:0] active_view;

  dls_seq #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cancel(cancel_evt),
    .head_addr(node_addr), .next_addr(node_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .word_we(word_we), .word_idx(word_idx), .word_data(word_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .mv_done(mv_done),
    .cmd_take(cmd_take), .cmd_fin(cmd_fin), .list_end(list_end),
    .fetch_err(fetch_err), .cmd_live(cmd_live), .seq_idle(seq_idle)
  );

  dls_regs #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W),
             .OFF_W(OFF_W), .WORDS(WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_idle(seq_idle),
    .word_we(word_we), .word_idx(word_idx), .word_data(word_data),
    .cmd_fin(cmd_fin), .list_end(list_end), .fetch_err(fetch_err),
    .active_view(active_view), .go(go), .cancel_evt(cancel_evt),
    .err_flag(err_flag), .node_addr(node_addr), .src_addr(cmd_src),
    .dst_addr(cmd_dst), .size_m1(cmd_len), .rd_inc(cmd_rd_inc),
    .wr_inc(cmd_wr_inc), .rd_width(cmd_rd_width), .wr_width(cmd_wr_width)
  );

  dls_remain #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_remain (
    .clk(clk), .rst_n(rst_n), .load(cmd_take), .size_m1(cmd_len),
    .step_vld(mv_step && cmd_live), .step_bytes(mv_bytes),
    .clear(cmd_fin || cancel_evt), .active_view(active_view)
  );

  assign cmd_abort = cancel_evt && cmd_live;

endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cancel_evt,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rvalid,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [AW-1:0]    cmd_src,
  input logic [AW-1:0]    cmd_dst,
  input logic [LEN_W-1:0] cmd_len,
  input logic             cmd_live,
  input logic [LEN_W-1:0] active_view,
  input logic             err_flag
);

  // R7
  cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (!mem_req && !cmd_valid));

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !cancel_evt) |=> (mem_req && $stable(mem_addr)));

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !cancel_evt) |=>
      (cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)));

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, cmd_valid}));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R8
  idle_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_live |-> (active_view == '1));

endmodule

bind dma_list_seq dls_chk #(.AW(AW), .LEN_W(LEN_W)) u_dls_chk (
  .clk(clk), .rst_n(rst_n), .cancel_evt(cancel_evt), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
  .cmd_len(cmd_len), .cmd_live(cmd_live), .active_view(active_view),
  .err_flag(err_flag)
);

// File: tb/test_dma_list_seq.sv
module test_dma_list_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [31:0] cmd_src, cmd_dst;
  logic [23:0] cmd_len;
  logic        cmd_rd_inc, cmd_wr_inc;
  logic [2:0]  cmd_rd_width, cmd_wr_width;
  logic        cmd_abort;
  logic        mv_step = 1'b0;
  logic [3:0]  mv_bytes = '0;
  logic        mv_done = 1'b0;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] mem [0:63];
  logic [31:0] rd_log [0:255];
  int          rd_n = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  dma_list_seq i_dma_list_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rerr(mem_rerr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .cmd_rd_inc(cmd_rd_inc), .cmd_wr_inc(cmd_wr_inc),
    .cmd_rd_width(cmd_rd_width), .cmd_wr_width(cmd_wr_width),
    .cmd_abort(cmd_abort), .mv_step(mv_step), .mv_bytes(mv_bytes),
    .mv_done(mv_done)
  );

  // memory model: answers a held request one half cycle later, one word per two cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 1'b0;
    end else if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[7:2]];
      mem_rerr   <= (mem_addr == err_addr);
      if (rd_n < 256) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end else begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 1'b0;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    tick();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cmd(input string req);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (cmd_valid) begin ok = 1'b1; break; end
      tick();
    end
    chk(req, {31'd0, ok}, 32'd1);
  endtask

  task automatic finish_cmd();
    tick();
    mv_done = 1'b1;
    tick();
    mv_done = 1'b0;
  endtask

  task automatic put_node(input int base, input logic [31:0] gcfg, input logic [31:0] ra,
                          input logic [31:0] wa, input logic [31:0] sz, input logic [31:0] nxt);
    mem[base/4 + 0] = gcfg;
    mem[base/4 + 1] = 32'hA5A5_0000 | base;
    mem[base/4 + 2] = ra;
    mem[base/4 + 3] = wa;
    mem[base/4 + 4] = sz;
    mem[base/4 + 5] = nxt;
    mem[base/4 + 6] = 32'h0;
    mem[base/4 + 7] = 32'h11;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    reg_read(6'h1C, v); chk("R1 ctrl", v, 32'h0);
    reg_read(6'h18, v); chk("R1 count", v, 32'h0);
    reg_read(6'h30, v); chk("R1 active", v, 32'h00FF_FFFF);
  endtask

  task automatic t_chain(input logic [31:0] ctrl_end, input logic [31:0] cnt_end);
    logic [31:0] v;
    logic        seq_ok;
    int          r0;
    r0 = rd_n;
    cmd_ready = 1'b0;
    reg_write(6'h14, 32'h20);
    reg_write(6'h1C, 32'h11);
    wait_cmd("R2 first command");
    seq_ok = (rd_n - r0 == 8);
    for (int i = 0; i < 8; i++) if (rd_log[r0 + i] != 32'h20 + 4 * i) seq_ok = 1'b0;
    chk("R2 fetch order", {31'd0, seq_ok}, 32'd1);
    chk("R3 src", cmd_src, 32'h1000_0000);
    chk("R3 dst", cmd_dst, 32'h2000_0000);
    chk("R3 len", {8'd0, cmd_len}, 32'h40);
    chk("R3 flags", {24'd0, cmd_rd_inc, cmd_wr_inc, cmd_rd_width, cmd_wr_width},
        {24'd0, 1'b1, 1'b1, 3'd2, 3'd2});
    reg_read(6'h00, v); chk("R3 gcfg reg", v, 32'h1122);
    reg_read(6'h04, v); chk("R3 rport reg", v, 32'hA5A5_0020);
    reg_read(6'h10, v); chk("R3 size reg", v, 32'h40);
    reg_read(6'h14, v); chk("R4 node reg", v, 32'h60);
    reg_read(6'h30, v); chk("R8 before accept", v, 32'h00FF_FFFF);
    tick(); tick(); tick();
    chk("R3 held", {31'd0, cmd_valid}, 32'd1);
    cmd_ready = 1'b1;
    tick();
    reg_read(6'h30, v); chk("R8 loaded", v, 32'h40);
    mv_step = 1'b1; mv_bytes = 4'd4;
    tick();
    mv_step = 1'b0;
    reg_read(6'h30, v); chk("R8 step", v, 32'h3C);
    reg_write(6'h14, 32'hBAD0);
    reg_read(6'h14, v); chk("R10 node write ignored", v, 32'h60);
    reg_write(6'h1C, 32'h0);
    reg_read(6'h1C, v); chk("R10 ctrl write ignored", v, ctrl_end | 32'h10);
    finish_cmd();
    r0 = rd_n;
    wait_cmd("R4 second command");
    chk("R4 next fetch addr", rd_log[r0], 32'h60);
    chk("R3 second src", cmd_src, 32'h1000_0800);
    chk("R3 second flags", {24'd0, cmd_rd_inc, cmd_wr_inc, cmd_rd_width, cmd_wr_width},
        {24'd0, 1'b1, 1'b0, 3'd3, 3'd0});
    tick();
    mv_step = 1'b1; mv_bytes = 4'd8;
    tick();
    mv_step = 1'b0;
    reg_read(6'h30, v); chk("R8 saturate", v, 32'h00FF_FFFF);
    finish_cmd();
    r0 = rd_n;
    repeat (20) tick();
    chk("R5 no more reads", rd_n - r0, 32'd0);
    chk("R5 idle", {30'd0, mem_req, cmd_valid}, 32'd0);
    reg_read(6'h1C, v); chk("R5 list cleared", v, ctrl_end);
    reg_read(6'h18, v); chk("R5 count", v, cnt_end);
    reg_read(6'h30, v); chk("R8 after done", v, 32'h00FF_FFFF);
  endtask

  task automatic t_cyclic();
    logic [31:0] v;
    reg_write(6'h14, 32'h80);
    reg_write(6'h1C, 32'h11);
    for (int k = 0; k < 3; k++) begin
      wait_cmd("R6 loop command");
      chk("R6 loop fetch addr", rd_log[rd_n - 8], 32'h80);
      chk("R6 loop src", cmd_src, 32'h3000_0000);
      tick();
      finish_cmd();
    end
    reg_read(6'h1C, v); chk("R6 list stays", v, 32'h11);
    reg_read(6'h18, v); chk("R6 count", v, 32'd5);
    cmd_ready = 1'b0;
    wait_cmd("R6 fourth command");
    tick();
    reg_we = 1'b1; reg_addr = 6'h1C; reg_wdata = 32'h0010_0000;
    #1;
    chk("R7 abort", {31'd0, cmd_abort}, 32'd1);
    tick();
    reg_we = 1'b0;
    chk("R7 cmd dropped", {30'd0, mem_req, cmd_valid}, 32'd0);
    reg_read(6'h1C, v); chk("R7 ctrl cleared", v, 32'h0);
    cmd_ready = 1'b1;
  endtask

  task automatic t_cancel_fetch();
    logic [31:0] v;
    int          r0;
    reg_write(6'h14, 32'h20);
    reg_write(6'h1C, 32'h11);
    tick(); tick(); tick();
    chk("R7 fetching", {31'd0, mem_req}, 32'd1);
    reg_write(6'h1C, 32'h0010_0000);
    chk("R7 fetch stopped", {31'd0, mem_req}, 32'd0);
    tick();
    r0 = rd_n;
    repeat (20) begin
      tick();
      if (cmd_valid) chk("R7 no command", 32'd1, 32'd0);
    end
    chk("R7 no reads", rd_n - r0, 32'd0);
    reg_read(6'h1C, v); chk("R7 ctrl after fetch cancel", v, 32'h0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int          r0;
    err_addr = 32'hC8;
    r0 = rd_n;
    reg_write(6'h14, 32'hC0);
    reg_write(6'h1C, 32'h11);
    repeat (30) begin
      tick();
      if (cmd_valid) chk("R9 no command", 32'd1, 32'd0);
    end
    chk("R9 reads stop", rd_n - r0, 32'd3);
    chk("R9 halted", {31'd0, mem_req}, 32'd0);
    reg_read(6'h1C, v); chk("R9 error bit", v, 32'h0100_0001);
    err_addr = 32'hFFFF_FFFF;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    put_node('h20, 32'h0000_1122, 32'h1000_0000, 32'h2000_0000, 32'hEE00_0040, 32'h60);
    put_node('h60, 32'h0000_0103, 32'h1000_0800, 32'h2000_0800, 32'h0000_0002, 32'h0);
    put_node('h80, 32'h0000_0022, 32'h3000_0000, 32'h4000_0000, 32'h0000_0010, 32'h80);
    put_node('hC0, 32'h0000_1122, 32'h5000_0000, 32'h6000_0000, 32'h0000_0010, 32'h0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_chain(32'h0000_0001, 32'd2);
    t_cyclic();
    t_cancel_fetch();
    t_error();
    t_chain(32'h0100_0001, 32'd7);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule